// File: doc/BRIEF.md
# Variable-Size Page Translation Array

This block turns a virtual word address into a physical word address. It keeps a small table of recently used pages and searches all of it at once. The requester presents a virtual page number and a word offset within the page. Three cycles later the block returns one of three outcomes: hit, bounds fault or miss. With the outcome it returns the physical address, the page size and the page attribute bits. A new lookup can start on every cycle, so back-to-back lookups stream through the pipeline without stalls.

Pages vary in length from 16 to 1024 words, in steps of 16 words. A virtual page always starts on a 1024-word boundary. A physical page may start on any 16-word boundary and fills contiguous words. The translated address is the page's physical start plus the offset. An offset that runs past the end of a short page is reported as a bounds fault.

Software manages the table through a write port. One operation installs an entry and the other invalidates one. Table walking and the handling of misses are the requester's job.

Top module: `page_xlat_array`

## Requirements
- R1: A lookup sampled with `req_valid` high at a clock edge produces `rsp_valid` high during the third cycle after that edge. A cycle without a lookup produces `rsp_valid` low three cycles later. One lookup is accepted per cycle.
- R2: On a hit, meaning the page number matches a valid entry and the offset lies inside the page, `rsp_hit` is 1 and `rsp_fault` is 0. `rsp_paddr` equals (start field × 16 + offset) modulo 2^24. `rsp_size` and `rsp_attr` carry the entry's stored values.
- R3: If the page number matches but the offset is greater than or equal to size × 16, then `rsp_fault` is 1, `rsp_hit` is 0 and `rsp_paddr` is 0. `rsp_size` and `rsp_attr` still report the entry.
- R4: If no valid entry matches, `rsp_hit`, `rsp_fault`, `rsp_paddr`, `rsp_size` and `rsp_attr` are all 0.
- R5: An install (`wr_op` = 0) whose page number is already held overwrites that entry in place. A page number is never held twice.
- R6: An install whose page number is not held goes into the lowest-indexed invalid entry, if one exists.
- R7: When the table is full, an install of a new page number replaces the entry chosen by a round-robin pointer. The pointer starts at 0 and advances by one, wrapping, only on such a replacement.
- R8: An invalidate (`wr_op` = 1) clears the entry holding its page number. If no entry holds it, nothing changes.
- R9: The size field counts 16-word units and is legal from 1 to 64. An install with size 0 or above 64 is ignored.
- R10: After reset, every entry is invalid, `rsp_valid` is low and the replacement pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request present |
| req_vpn | input | 22 | Virtual page number (virtual word address bits 31:10) |
| req_offset | input | 10 | Word offset within the page |
| wr_en | input | 1 | Table write strobe |
| wr_op | input | 1 | 0 = install, 1 = invalidate |
| wr_vpn | input | 22 | Page number to install or invalidate |
| wr_pstart | input | 20 | Physical start in 16-word units |
| wr_size | input | 7 | Page size in 16-word units (1..64) |
| wr_attr | input | 4 | Service attribute bits |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_fault | output | 1 | Offset beyond page end |
| rsp_paddr | output | 24 | Physical word address |
| rsp_size | output | 7 | Page size of the matched entry |
| rsp_attr | output | 4 | Attributes of the matched entry |

## Verification
Corrupt table state shows up at the ports as soon as that page is next looked up, three cycles after the request. A lost valid bit turns into a miss. A wrong start or size turns into a wrong address or a misplaced bounds fault. A wrong replacement pointer evicts the wrong page, so a later lookup of the page that should have survived misses. The bench sweeps every offset of several pages of different sizes, including one whose address wraps. It then tracks the eviction order through in-place, free-slot, full-table and rejected installs by looking up every page after each write.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   // Table write operations
   typedef enum logic {
      WR_INSTALL    = 1'b0,
      WR_INVALIDATE = 1'b1
   } wr_op_e;
endpackage

// File: rtl/xlat_match.sv
// Parallel key comparison across every table slot.
module xlat_match #(
   parameter int N     = 64,
   parameter int KEY_W = 22
) (
   input  logic [N-1:0]            valid_i,
   input  logic [N-1:0][KEY_W-1:0] keys_i,
   input  logic [KEY_W-1:0]        probe_i,
   output logic [N-1:0]            hit_o
);
   for (genvar i = 0; i < N; i++) begin : g_cmp
      assign hit_o[i] = valid_i[i] && (keys_i[i] == probe_i);
   end
endmodule

// File: rtl/xlat_victim.sv
// Round-robin replacement pointer.
module xlat_victim #(
   parameter int N     = 64,
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance_i,
   output logic [IDX_W-1:0] ptr_o
);
   logic [IDX_W-1:0] ptr_q;

   if ((N & (N - 1)) == 0) begin : g_pow2
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         ptr_q <= '0;
         else if (advance_i) ptr_q <= ptr_q + 1'b1;
      end
   end else begin : g_wrap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         ptr_q <= '0;
         else if (advance_i) ptr_q <= (ptr_q == IDX_W'(N - 1)) ? '0 : ptr_q + 1'b1;
      end
   end

   assign ptr_o = ptr_q;

   // R7
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !advance_i |=> $stable(ptr_q));
   // R7
   ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(ptr_q) < N);
endmodule

// File: rtl/xlat_table.sv
// Entry storage with install / invalidate and slot selection.
module xlat_table #(
   parameter int N         = 64,
   parameter int IDX_W     = 6,
   parameter int VPN_W     = 22,
   parameter int PS_W      = 20,
   parameter int SZ_W      = 7,
   parameter int AT_W      = 4,
   parameter int MAX_UNITS = 64
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  xlat_pkg::wr_op_e       wr_op,
   input  logic [VPN_W-1:0]       wr_vpn,
   input  logic [PS_W-1:0]        wr_pstart,
   input  logic [SZ_W-1:0]        wr_size,
   input  logic [AT_W-1:0]        wr_attr,
   output logic [N-1:0]           valid_o,
   output logic [N-1:0][VPN_W-1:0] vpn_o,
   output logic [N-1:0][PS_W-1:0]  pstart_o,
   output logic [N-1:0][SZ_W-1:0]  size_o,
   output logic [N-1:0][AT_W-1:0]  attr_o
);
   import xlat_pkg::*;

   logic [N-1:0]            valid_q;
   logic [N-1:0][VPN_W-1:0] vpn_q;
   logic [N-1:0][PS_W-1:0]  pstart_q;
   logic [N-1:0][SZ_W-1:0]  size_q;
   logic [N-1:0][AT_W-1:0]  attr_q;

   logic [N-1:0]     wmatch;
   logic [IDX_W-1:0] match_idx, free_idx, tgt_idx, victim;
   logic             any_match, any_free, size_ok, do_install, do_inval, advance;

   xlat_match #(.N(N), .KEY_W(VPN_W)) u_wmatch (
      .valid_i (valid_q),
      .keys_i  (vpn_q),
      .probe_i (wr_vpn),
      .hit_o   (wmatch)
   );

   xlat_victim #(.N(N), .IDX_W(IDX_W)) u_victim (
      .clk       (clk),
      .rst_n     (rst_n),
      .advance_i (advance),
      .ptr_o     (victim)
   );

   always_comb begin
      match_idx = '0;
      free_idx  = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (wmatch[i])   match_idx = IDX_W'(i);
         if (!valid_q[i]) free_idx  = IDX_W'(i);
      end
      any_match  = |wmatch;
      any_free   = ~&valid_q;
      size_ok    = (wr_size != '0) && (wr_size <= SZ_W'(MAX_UNITS));
      do_install = wr_en && (wr_op == WR_INSTALL) && size_ok;
      do_inval   = wr_en && (wr_op == WR_INVALIDATE);
      tgt_idx    = any_match ? match_idx : (any_free ? free_idx : victim);
      advance    = do_install && !any_match && !any_free;
   end

   for (genvar i = 0; i < N; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_q[i]  <= 1'b0;
            vpn_q[i]    <= '0;
            pstart_q[i] <= '0;
            size_q[i]   <= '0;
            attr_q[i]   <= '0;
         end else if (do_install && (tgt_idx == IDX_W'(i))) begin
            valid_q[i]  <= 1'b1;
            vpn_q[i]    <= wr_vpn;
            pstart_q[i] <= wr_pstart;
            size_q[i]   <= wr_size;
            attr_q[i]   <= wr_attr;
         end else if (do_inval && wmatch[i]) begin
            valid_q[i]  <= 1'b0;
         end
      end
   end

   assign valid_o  = valid_q;
   assign vpn_o    = vpn_q;
   assign pstart_o = pstart_q;
   assign size_o   = size_q;
   assign attr_o   = attr_q;

   // R5
   match_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wmatch));
   // R8
   drop_only_on_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(valid_q) < $past($countones(valid_q))) |-> $past(do_inval));
endmodule

// File: rtl/page_xlat_array.sv
// Three-stage associative page translation with variable page sizes.
module page_xlat_array #(
   parameter int ENTRIES  = 64,
   parameter int VA_W     = 32,
   parameter int PG_OFF_W = 10,
   parameter int GRAN_W   = 4,
   parameter int PA_W     = 24,
   parameter int AT_W     = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic [VA_W-PG_OFF_W-1:0] req_vpn,
   input  logic [PG_OFF_W-1:0]      req_offset,
   input  logic                     wr_en,
   input  logic                     wr_op,
   input  logic [VA_W-PG_OFF_W-1:0] wr_vpn,
   input  logic [PA_W-GRAN_W-1:0]   wr_pstart,
   input  logic [$clog2((1 << (PG_OFF_W - GRAN_W)) + 1)-1:0] wr_size,
   input  logic [AT_W-1:0]          wr_attr,
   output logic                     rsp_valid,
   output logic                     rsp_hit,
   output logic                     rsp_fault,
   output logic [PA_W-1:0]          rsp_paddr,
   output logic [$clog2((1 << (PG_OFF_W - GRAN_W)) + 1)-1:0] rsp_size,
   output logic [AT_W-1:0]          rsp_attr
);
   localparam int VPN_W     = VA_W - PG_OFF_W;
   localparam int PS_W      = PA_W - GRAN_W;
   localparam int MAX_UNITS = 1 << (PG_OFF_W - GRAN_W);
   localparam int SZ_W      = $clog2(MAX_UNITS + 1);
   localparam int IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam int CMP_W     = SZ_W + GRAN_W;

   // Elaboration-time parameter checks
   if (ENTRIES < 2) begin : g_bad_entries
      $error("page_xlat_array: ENTRIES must be at least 2");
   end
   if (PG_OFF_W <= GRAN_W) begin : g_bad_gran
      $error("page_xlat_array: page offset must be wider than granule");
   end
   if (PA_W <= PG_OFF_W || VA_W <= PG_OFF_W) begin : g_bad_addr
      $error("page_xlat_array: address widths must exceed page offset");
   end

   // Table
   logic [ENTRIES-1:0]            t_valid;
   logic [ENTRIES-1:0][VPN_W-1:0] t_vpn;
   logic [ENTRIES-1:0][PS_W-1:0]  t_pstart;
   logic [ENTRIES-1:0][SZ_W-1:0]  t_size;
   logic [ENTRIES-1:0][AT_W-1:0]  t_attr;

   xlat_table #(
      .N(ENTRIES), .IDX_W(IDX_W), .VPN_W(VPN_W), .PS_W(PS_W),
      .SZ_W(SZ_W), .AT_W(AT_W), .MAX_UNITS(MAX_UNITS)
   ) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_op     (xlat_pkg::wr_op_e'(wr_op)),
      .wr_vpn    (wr_vpn),
      .wr_pstart (wr_pstart),
      .wr_size   (wr_size),
      .wr_attr   (wr_attr),
      .valid_o   (t_valid),
      .vpn_o     (t_vpn),
      .pstart_o  (t_pstart),
      .size_o    (t_size),
      .attr_o    (t_attr)
   );

   // Stage 1: capture request
   logic                s1_valid;
   logic [VPN_W-1:0]    s1_vpn;
   logic [PG_OFF_W-1:0] s1_off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_vpn   <= '0;
         s1_off   <= '0;
      end else begin
         s1_valid <= req_valid;
         s1_vpn   <= req_vpn;
         s1_off   <= req_offset;
      end
   end

   // Stage 2: associative search and field select
   logic [ENTRIES-1:0] l_hit;
   logic [PS_W-1:0]    sel_pstart;
   logic [SZ_W-1:0]    sel_size;
   logic [AT_W-1:0]    sel_attr;

   xlat_match #(.N(ENTRIES), .KEY_W(VPN_W)) u_lmatch (
      .valid_i (t_valid),
      .keys_i  (t_vpn),
      .probe_i (s1_vpn),
      .hit_o   (l_hit)
   );

   always_comb begin
      sel_pstart = '0;
      sel_size   = '0;
      sel_attr   = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         sel_pstart |= {PS_W{l_hit[i]}} & t_pstart[i];
         sel_size   |= {SZ_W{l_hit[i]}} & t_size[i];
         sel_attr   |= {AT_W{l_hit[i]}} & t_attr[i];
      end
   end

   logic                s2_valid, s2_match;
   logic [PG_OFF_W-1:0] s2_off;
   logic [PS_W-1:0]     s2_pstart;
   logic [SZ_W-1:0]     s2_size;
   logic [AT_W-1:0]     s2_attr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_valid  <= 1'b0;
         s2_match  <= 1'b0;
         s2_off    <= '0;
         s2_pstart <= '0;
         s2_size   <= '0;
         s2_attr   <= '0;
      end else begin
         s2_valid  <= s1_valid;
         s2_match  <= |l_hit;
         s2_off    <= s1_off;
         s2_pstart <= sel_pstart;
         s2_size   <= sel_size;
         s2_attr   <= sel_attr;
      end
   end

   // Stage 3: bounds check and address add
   logic            oob;
   logic [PA_W-1:0] sum;

   always_comb begin
      oob = CMP_W'(s2_off) >= {s2_size, {GRAN_W{1'b0}}};
      sum = {s2_pstart, {GRAN_W{1'b0}}} + PA_W'(s2_off);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_paddr <= '0;
         rsp_size  <= '0;
         rsp_attr  <= '0;
      end else begin
         rsp_valid <= s2_valid;
         rsp_hit   <= s2_valid && s2_match && !oob;
         rsp_fault <= s2_valid && s2_match && oob;
         rsp_paddr <= (s2_valid && s2_match && !oob) ? sum : '0;
         rsp_size  <= (s2_valid && s2_match) ? s2_size : '0;
         rsp_attr  <= (s2_valid && s2_match) ? s2_attr : '0;
      end
   end

   // R1
   lat_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> ##3 rsp_valid);
   // R1
   lat_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> ##3 !rsp_valid);
   // R3
   hit_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !(rsp_hit && rsp_fault));
   // R4
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit && !rsp_fault) |-> (rsp_paddr == '0 && rsp_size == '0 && rsp_attr == '0));
   // R9
   hit_size_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_hit) |-> (rsp_size != '0 && rsp_size <= SZ_W'(MAX_UNITS)));
endmodule

// File: tb/tb_page_xlat_array.sv
module tb_page_xlat_array;
   localparam int N = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [21:0] req_vpn = '0;
   logic [9:0]  req_offset = '0;
   logic        wr_en = 1'b0;
   logic        wr_op = 1'b0;
   logic [21:0] wr_vpn = '0;
   logic [19:0] wr_pstart = '0;
   logic [6:0]  wr_size = '0;
   logic [3:0]  wr_attr = '0;
   logic        rsp_valid, rsp_hit, rsp_fault;
   logic [23:0] rsp_paddr;
   logic [6:0]  rsp_size;
   logic [3:0]  rsp_attr;

   always #2 clk = ~clk;

   page_xlat_array #(.ENTRIES(N)) dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_vpn(req_vpn), .req_offset(req_offset),
      .wr_en(wr_en), .wr_op(wr_op), .wr_vpn(wr_vpn), .wr_pstart(wr_pstart),
      .wr_size(wr_size), .wr_attr(wr_attr),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
      .rsp_paddr(rsp_paddr), .rsp_size(rsp_size), .rsp_attr(rsp_attr)
   );

   int errs = 0;
   int checks = 0;
   string phase = "R10";

   // Reference table
   logic        mv [N];
   logic [21:0] mvpn [N];
   logic [19:0] mps [N];
   logic [6:0]  msz [N];
   logic [3:0]  mat [N];
   int          mptr = 0;

   // Expectation pipeline (slot 2 is due now)
   logic        ev [3];
   logic        eh [3];
   logic        ef [3];
   logic [23:0] ea [3];
   logic [6:0]  es [3];
   logic [3:0]  et [3];
   string       en [3];

   task automatic model_install(input logic [21:0] v, input logic [19:0] p,
                                input logic [6:0] s, input logic [3:0] a);
      int tgt = -1;
      if (s == 0 || s > 64) return;                  // R9
      for (int i = 0; i < N; i++) if (mv[i] && mvpn[i] == v) tgt = i;   // R5
      if (tgt < 0) for (int i = N - 1; i >= 0; i--) if (!mv[i]) tgt = i; // R6
      if (tgt < 0) begin tgt = mptr; mptr = (mptr + 1) % N; end         // R7
      mv[tgt] = 1'b1; mvpn[tgt] = v; mps[tgt] = p; msz[tgt] = s; mat[tgt] = a;
   endtask

   task automatic model_inval(input logic [21:0] v);
      for (int i = 0; i < N; i++) if (mv[i] && mvpn[i] == v) mv[i] = 1'b0; // R8
   endtask

   task automatic step(input logic rv, input logic [21:0] v, input logic [9:0] off,
                       input logic we, input logic op, input logic [21:0] wv,
                       input logic [19:0] wp, input logic [6:0] ws, input logic [3:0] wa);
      logic h, f;
      logic [23:0] pa;
      logic [6:0] sz;
      logic [3:0] at;
      @(negedge clk);
      checks++;
      if (rsp_valid !== ev[2]) begin
         errs++;
         $display("FAIL R1 [%s] rsp_valid actual=%0b expected=%0b", en[2], rsp_valid, ev[2]);
      end else if (ev[2] && {rsp_hit, rsp_fault, rsp_paddr, rsp_size, rsp_attr} !==
                            {eh[2], ef[2], ea[2], es[2], et[2]}) begin
         errs++;
         $display("FAIL %s hit/fault/paddr/size/attr actual=%0b/%0b/%h/%0d/%h expected=%0b/%0b/%h/%0d/%h",
                  en[2], rsp_hit, rsp_fault, rsp_paddr, rsp_size, rsp_attr,
                  eh[2], ef[2], ea[2], es[2], et[2]);
      end
      for (int k = 2; k > 0; k--) begin
         ev[k] = ev[k-1]; eh[k] = eh[k-1]; ef[k] = ef[k-1];
         ea[k] = ea[k-1]; es[k] = es[k-1]; et[k] = et[k-1]; en[k] = en[k-1];
      end
      h = 0; f = 0; pa = '0; sz = '0; at = '0;
      for (int i = 0; i < N; i++) begin
         if (mv[i] && mvpn[i] == v) begin
            sz = msz[i]; at = mat[i];
            if (int'(off) >= int'(msz[i]) * 16) f = 1;                 // R3
            else begin h = 1; pa = {mps[i], 4'b0} + 24'(off); end       // R2
         end
      end
      ev[0] = rv; eh[0] = h; ef[0] = f; ea[0] = pa; es[0] = sz; et[0] = at;
      en[0] = rv ? (h ? {"R2 ", phase} : (f ? {"R3 ", phase} : {"R4 ", phase})) : {"R1 ", phase};
      req_valid = rv; req_vpn = v; req_offset = off;
      wr_en = we; wr_op = op; wr_vpn = wv; wr_pstart = wp; wr_size = ws; wr_attr = wa;
      if (we) begin
         if (op == 1'b0) model_install(wv, wp, ws, wa);
         else            model_inval(wv);
      end
   endtask

   task automatic look(input logic [21:0] v, input logic [9:0] off);
      step(1'b1, v, off, 1'b0, 1'b0, '0, '0, '0, '0);
   endtask
   task automatic idle();
      step(1'b0, '0, '0, 1'b0, 1'b0, '0, '0, '0, '0);
   endtask
   task automatic inst(input logic [21:0] v, input logic [19:0] p,
                       input logic [6:0] s, input logic [3:0] a);
      step(1'b0, '0, '0, 1'b1, 1'b0, v, p, s, a);
   endtask
   task automatic inval(input logic [21:0] v);
      step(1'b0, '0, '0, 1'b1, 1'b1, v, '0, '0, '0);
   endtask

   localparam logic [21:0] VA = 22'h000010, VB = 22'h3FFFFF, VC = 22'h00002A,
                           VD = 22'h155555, VE = 22'h000077, VF = 22'h0ABC00,
                           VG = 22'h200001, VH = 22'h0F0F0F, VI = 22'h111111,
                           VJ = 22'h222222, VX = 22'h000011;

   initial begin
      #(4 * 150000);
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) mv[i] = 1'b0;
      for (int k = 0; k < 3; k++) begin
         ev[k] = 0; eh[k] = 0; ef[k] = 0; ea[k] = '0; es[k] = '0; et[k] = '0; en[k] = "R10 reset";
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R10: idle response and empty table after reset
      phase = "R10";
      idle(); idle();
      look(22'h0, 10'd0); look(VA, 10'd5); idle(); idle(); idle();

      // Fill: various sizes, one page wrapping at the top of physical space
      phase = "R6 fill";
      inst(VA, 20'h00100, 7'd1,  4'h1);
      inst(VB, 20'hFFFFF, 7'd64, 4'h2);
      inst(VC, 20'h12345, 7'd5,  4'h3);
      inst(VD, 20'h80000, 7'd33, 4'h4);

      // R2 R3 R4: sweep every offset for four pages and one absent page
      phase = "R2/R3 sweep";
      for (int off = 0; off < 1024; off++) begin
         look(VA, 10'(off)); look(VB, 10'(off)); look(VC, 10'(off));
         look(VD, 10'(off)); look(VX, 10'(off));
      end

      // R7: full table, victims taken in order 0 then 1
      phase = "R7 replace";
      inst(VE, 20'h00200, 7'd2, 4'h5);
      look(VA, 10'd0); look(VE, 10'd31); look(VE, 10'd32);
      inst(VF, 20'h00300, 7'd8, 4'h6);
      look(VB, 10'd0); look(VF, 10'd127); look(VC, 10'd0); look(VD, 10'd0);

      // R5: reinstall C in place, no eviction
      phase = "R5 in-place";
      inst(VC, 20'h54321, 7'd2, 4'h7);
      look(VC, 10'd31); look(VC, 10'd32); look(VD, 10'd0); look(VE, 10'd0); look(VF, 10'd0);

      // R8 then R6: invalidate D, next install fills its slot, C survives
      phase = "R8 invalidate";
      inval(VD);
      look(VD, 10'd0);
      phase = "R6 free slot";
      inst(VG, 20'h00400, 7'd64, 4'h8);
      look(VG, 10'd1023); look(VC, 10'd3); look(VE, 10'd1); look(VF, 10'd1);
      // R7: pointer did not move on in-place or free-slot installs, so C goes now
      phase = "R7 pointer hold";
      inst(VH, 20'h00500, 7'd4, 4'h9);
      look(VC, 10'd3); look(VH, 10'd63); look(VH, 10'd64);

      // R8: invalidate of an absent page changes nothing
      phase = "R8 absent";
      inval(VX);
      look(VE, 10'd2); look(VF, 10'd2); look(VG, 10'd2); look(VH, 10'd2);

      // R9: illegal sizes ignored, nothing evicted
      phase = "R9 illegal size";
      inst(VI, 20'h00600, 7'd0,  4'hA);
      inst(VJ, 20'h00700, 7'd65, 4'hB);
      look(VI, 10'd0); look(VJ, 10'd0);
      look(VE, 10'd3); look(VF, 10'd3); look(VG, 10'd3); look(VH, 10'd3);

      phase = "R1 drain";
      idle(); idle(); idle(); idle();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule